// File: doc/BRIEF.md
# Bootloader Command Frame Receiver

This block sits behind a UART byte receiver and pulls bootloader command frames out of the incoming byte stream. A frame opens with the two marker bytes 0x57 and 0xAB. A command byte follows, then a 16-bit payload length sent low byte first, then that many payload bytes, and last a checksum byte. The receiver hunts for the marker pair and collects the fields, storing the payload in a small local buffer. It then checks the checksum and reports the frame to a command handler.

A good frame produces a one-cycle valid strobe. The command code and the length are then available on output ports, and the payload bytes can be read from the buffer through an address/data read port. A bad checksum, an oversized length or a stalled partial frame each produces its own one-cycle error strobe, and the parser goes back to hunting. Stray bytes between frames, and bytes that break the marker pair, are discarded.

Top module: `isp_frame_rx`

## Requirements
- R1: After reset the parser is hunting, and all four strobes (`frm_valid`, `err_csum`, `err_ovf`, `err_tmo`) are low.
- R2: While hunting, any byte other than 0x57 is discarded. A frame is recognised only when 0x57 is followed directly by 0xAB.
- R3: If the byte after a 0x57 is not 0xAB, the attempt is dropped. If that byte is itself 0x57, it is taken as a new first marker byte, so 0x57 0x57 0xAB still starts a frame.
- R4: After the marker pair, the parser takes the command byte, then length bits 7:0, then length bits 15:8. Payload byte k is stored at buffer address k and can be read on `rd_data` by driving `rd_addr`.
- R5: When the checksum byte equals the low 8 bits of the sum of the command, both length bytes and all payload bytes, `frm_valid` is high for exactly the cycle after the clock edge that accepts the checksum byte. `frm_cmd` and `frm_len` carry that frame's fields during that cycle.
- R6: When the checksum byte does not match, `err_csum` pulses for that same cycle, `frm_valid` stays low, and the parser returns to hunting.
- R7: A length above MAX_LEN makes `err_ovf` pulse in the cycle after the high length byte is accepted. The frame is then abandoned and the parser hunts. A length equal to MAX_LEN is accepted.
- R8: Once a frame is under way (a first marker byte has been seen), TIMEOUT consecutive cycles without an incoming byte make `err_tmo` pulse once and return the parser to hunting.
- R9: A frame with length zero carries no payload. Its checksum byte follows the high length byte directly.
- R10: At most one of the four strobes is high in any cycle.
- R11: Idle cycles while hunting never raise `err_tmo`, however long they last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Incoming byte strobe, one cycle per byte |
| rx_byte | input | 8 | Incoming byte |
| rd_addr | input | $clog2(MAX_LEN) | Payload buffer read address |
| rd_data | output | 8 | Payload byte at `rd_addr` (combinational read) |
| frm_valid | output | 1 | Good frame strobe |
| err_csum | output | 1 | Checksum mismatch strobe |
| err_ovf | output | 1 | Length above MAX_LEN strobe |
| err_tmo | output | 1 | Inter-byte timeout strobe |
| frm_cmd | output | 8 | Command code of the latest frame |
| frm_len | output | 16 | Payload length of the latest frame |

## Verification
The hardest situations to reach are those where the resynchronisation and abort rules interact with the payload path. Examples are a frame cut off partway through its payload, a stall right after a lone first marker byte, and a repeated 0x57 just before 0xAB. The stimulus builds these directly from byte-level driver calls, holding the byte input idle for a set number of cycles where a stall is needed. Each abort is followed by a clean frame, which proves that the parser recovered with a correct checksum sum and a correct buffer index. Payload lengths run from zero up to exactly the buffer size, and one length is a single byte too long.

// File: rtl/isp_frame_rx.sv
module isp_frame_rx #(
  parameter int MAX_LEN = 64,
  parameter int TIMEOUT = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_byte,
  input  logic [$clog2(MAX_LEN)-1:0] rd_addr,
  output logic [7:0]                 rd_data,
  output logic                       frm_valid,
  output logic                       err_csum,
  output logic                       err_ovf,
  output logic                       err_tmo,
  output logic [7:0]                 frm_cmd,
  output logic [15:0]                frm_len
);
  localparam int AW = $clog2(MAX_LEN);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [7:0] SYNC_A = 8'h57;
  localparam logic [7:0] SYNC_B = 8'hAB;

  typedef enum logic [2:0] {HUNT, SYNC2, CMD, LENL, LENH, DATA, CSUM} st_t;

  st_t         state;
  logic [7:0]  cmd_q, sum_q;
  logic [15:0] len_q, idx_q;
  logic [TW-1:0] idle_q;
  logic [7:0]  buf_q [MAX_LEN];

  wire [15:0] len_full = {rx_byte, len_q[7:0]};
  wire [7:0]  sum_nxt  = sum_q + rx_byte;
  wire [15:0] idx_nxt  = idx_q + 16'd1;

  assign frm_cmd = cmd_q;
  assign frm_len = len_q;
  assign rd_data = buf_q[rd_addr];

  always_ff @(posedge clk)
    if (rx_valid && state == DATA) buf_q[idx_q[AW-1:0]] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= HUNT;
      cmd_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      sum_q     <= '0;
      idle_q    <= '0;
      frm_valid <= 1'b0;
      err_csum  <= 1'b0;
      err_ovf   <= 1'b0;
      err_tmo   <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      err_csum  <= 1'b0;
      err_ovf   <= 1'b0;
      err_tmo   <= 1'b0;
      if (rx_valid) begin
        idle_q <= '0;
        unique case (state)
          HUNT:  if (rx_byte == SYNC_A) state <= SYNC2;
          SYNC2: begin
            if (rx_byte == SYNC_B)      state <= CMD;
            else if (rx_byte != SYNC_A) state <= HUNT;
          end
          CMD: begin
            cmd_q <= rx_byte;
            sum_q <= rx_byte;
            state <= LENL;
          end
          LENL: begin
            len_q[7:0] <= rx_byte;
            sum_q      <= sum_nxt;
            state      <= LENH;
          end
          LENH: begin
            len_q[15:8] <= rx_byte;
            sum_q       <= sum_nxt;
            idx_q       <= '0;
            if (len_full > 16'(MAX_LEN)) begin
              err_ovf <= 1'b1;
              state   <= HUNT;
            end else if (len_full == 16'd0) begin
              state <= CSUM;
            end else begin
              state <= DATA;
            end
          end
          DATA: begin
            sum_q <= sum_nxt;
            idx_q <= idx_nxt;
            if (idx_nxt == len_q) state <= CSUM;
          end
          CSUM: begin
            if (rx_byte == sum_q) frm_valid <= 1'b1;
            else                  err_csum  <= 1'b1;
            state <= HUNT;
          end
          default: state <= HUNT;
        endcase
      end else if (state != HUNT) begin
        if (idle_q == TW'(TIMEOUT - 1)) begin
          idle_q  <= '0;
          err_tmo <= 1'b1;
          state   <= HUNT;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end else begin
        idle_q <= '0;
      end
    end
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_valid, err_csum, err_ovf, err_tmo}));

  // R5
  valid_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(rx_valid));

  // R5
  valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_len <= 16'(MAX_LEN));

  // R7
  ovf_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> frm_len > 16'(MAX_LEN));

  // R8
  tmo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |-> !$past(rx_valid));

  // R8
  tmo_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |-> state == HUNT);

  // R11
  hunt_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HUNT && !rx_valid) |=> !err_tmo);
endmodule

// File: tb/tb_isp_frame_rx.sv
`timescale 1ns/1ps
module tb_isp_frame_rx;
  localparam int MAXL = 64;
  localparam int TMO  = 40;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data, frm_cmd;
  logic [15:0] frm_len;
  logic frm_valid, err_csum, err_ovf, err_tmo;

  always #2.5 clk = ~clk;

  isp_frame_rx #(.MAX_LEN(MAXL), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .frm_valid(frm_valid),
    .err_csum(err_csum), .err_ovf(err_ovf), .err_tmo(err_tmo),
    .frm_cmd(frm_cmd), .frm_len(frm_len));

  int tests = 0, fails = 0;
  int exp_kind[$];
  logic [7:0] exp_cmd[$];
  logic [15:0] exp_len[$];
  logic [7:0] exp_pl[$];
  logic [7:0] tx_pl [300];
  string kname [4] = '{"R5 valid", "R6 csum", "R7 ovf", "R8 tmo"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input int len, input bit bad);
    logic [7:0] s;
    s = cmd + len[7:0] + len[15:8];
    for (int i = 0; i < len; i++) s += tx_pl[i];
    if (bad) s ^= 8'h01;
    if (len > MAXL) begin
      exp_kind.push_back(2);
    end else if (bad) begin
      exp_kind.push_back(1);
    end else begin
      exp_kind.push_back(0);
      exp_cmd.push_back(cmd);
      exp_len.push_back(16'(len));
      for (int i = 0; i < len; i++) exp_pl.push_back(tx_pl[i]);
    end
    put(8'h57); put(8'hAB); put(cmd); put(len[7:0]); put(len[15:8]);
    if (len <= MAXL) begin
      for (int i = 0; i < len; i++) put(tx_pl[i]);
      put(s);
    end
    idle(30);
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) tx_pl[i] = 8'((i * 37 + seed) ^ (i >> 2));
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (frm_valid | err_csum | err_ovf | err_tmo)) begin
        int k;
        k = frm_valid ? 0 : err_csum ? 1 : err_ovf ? 2 : 3;
        if (exp_kind.size() == 0) begin
          check(1'b0, "R10 R11 unexpected strobe", k, -1);
        end else begin
          int e;
          e = exp_kind.pop_front();
          check(k == e, kname[e], k, e);
          if (e == 0 && k == 0) begin
            logic [7:0] c;
            logic [15:0] l;
            bit ok;
            c = exp_cmd.pop_front();
            l = exp_len.pop_front();
            check(frm_cmd == c, "R4 cmd", frm_cmd, c);
            check(frm_len == l, "R4 R9 len", frm_len, l);
            ok = 1'b1;
            for (int i = 0; i < int'(l); i++) begin
              logic [7:0] pb;
              pb = exp_pl.pop_front();
              rd_addr = 6'(i);
              #0.05;
              if (rd_data != pb) begin
                ok = 1'b0;
                $display("FAIL R4 payload[%0d] actual=%0h expected=%0h", i, rd_data, pb);
              end
            end
            tests++;
            if (!ok) fails++;
          end
        end
      end
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(5);
    // R1 reset state
    check({frm_valid, err_csum, err_ovf, err_tmo} == 4'b0, "R1 strobes",
          {frm_valid, err_csum, err_ovf, err_tmo}, 0);
    rst_n = 1'b1;
    idle(3);
    check({frm_valid, err_csum, err_ovf, err_tmo} == 4'b0, "R1 after release",
          {frm_valid, err_csum, err_ovf, err_tmo}, 0);

    // R2 garbage before the marker pair
    put(8'h00); put(8'hFF); put(8'hAB); put(8'h12);
    tx_pl[0] = 8'h1F; tx_pl[1] = 8'h00;
    frame(8'hA7, 2, 1'b0);

    // R4 four-byte payload
    tx_pl[0] = 8'h40; tx_pl[1] = 8'h42; tx_pl[2] = 8'h0F; tx_pl[3] = 8'h00;
    frame(8'hC5, 4, 1'b0);

    // R3 doubled first marker, then a broken pair
    put(8'h57);
    tx_pl[0] = 8'h01;
    frame(8'hA2, 1, 1'b0);
    put(8'h57); put(8'h12);
    fill(14, 3);
    frame(8'hA8, 14, 1'b0);

    // R9 zero-length frame
    frame(8'hA2, 0, 1'b0);

    // lengths up to the buffer size (R7 boundary)
    fill(30, 9);  frame(8'hA3, 30, 1'b0);
    fill(61, 21); frame(8'hA5, 61, 1'b0);
    fill(64, 77); frame(8'hA6, 64, 1'b0);

    // R6 checksum mismatch, then recovery
    fill(4, 5); frame(8'hA4, 4, 1'b1);
    fill(4, 6); frame(8'hA4, 4, 1'b0);

    // R7 oversized lengths, then recovery
    frame(8'hA5, 65, 1'b0);
    frame(8'hA5, 256, 1'b0);
    fill(8, 44); frame(8'hA6, 8, 1'b0);

    // R8 stall inside the payload
    exp_kind.push_back(3);
    put(8'h57); put(8'hAB); put(8'hA5); put(8'h3D); put(8'h00);
    put(8'h11); put(8'h22); put(8'h33);
    idle(TMO + 10);
    // R8 stall after a lone first marker
    exp_kind.push_back(3);
    put(8'h57);
    idle(TMO + 10);
    fill(10, 2); frame(8'hA7, 10, 1'b0);

    // R11 long idle while hunting
    idle(TMO * 4);
    check({frm_valid, err_csum, err_ovf, err_tmo} == 4'b0, "R11 idle hunt",
          {frm_valid, err_csum, err_ovf, err_tmo}, 0);

    idle(10);
    check(exp_kind.size() == 0, "R10 all expected strobes seen", exp_kind.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule